// File: doc/BRIEF.md
# Dual-Subsystem Boot Bus Sequencer

Two processor subsystems share one external memory bus. After a system reset only the master subsystem runs. The slave subsystem stays in reset until the master has booted from external memory and copied its code into internal memory. This block tracks that boot order and drives two outputs: the bus-select line that gives the shared external interface to one side, and the reset line of the slave subsystem.

The master steers the block through control writes, which model a general-purpose output register that the master owns. One bit asks for the bus to be given to the slave. A second bit asks for the slave to be let out of reset. The hand-off always happens in a fixed order. The bus select moves first. The slave reset is released only after a settling window has passed. A slave-release request that arrives too early is rejected and recorded in a sticky error flag. A status output reports the current boot phase.

Top module: `boot_bus_seq`

## Requirements
- R1: A clock edge that samples `rst_n` low puts the block in its reset state, whatever phase it was in: `bus_to_slave`=0, `slave_rst_n`=0, `release_err`=0 and `boot_phase`=00.
- R2: In phase 00, boot starts only on a rising edge of `mst_rst_n`, meaning it was sampled low at one edge and high at the next. At that second edge the phase becomes 01. If `mst_rst_n` is already high when system reset ends, no boot starts. A bus hand-over write (`ctl_data` bit 0) in phase 00 has no effect.
- R3: In phase 01, a write (`ctl_wr`=1) with `ctl_data` bit 0 set drives `bus_to_slave` to 1 and the phase to 10 at that edge. `bus_to_slave` never rises from any other phase.
- R4: `slave_rst_n` is never high while `bus_to_slave` is low. In phase 10, with no release request, `slave_rst_n` stays low.
- R5: A write with `ctl_data` bit 1 set while `bus_to_slave` is 0 (phase 00 or 01) does not release the slave. It sets `release_err` at that edge, and `release_err` stays set until system reset.
- R6: Let E0 be the hand-over edge. A release request (`ctl_data` bit 1) sampled at edge Er in phase 10 raises `slave_rst_n` at edge max(Er, E0+SETTLE_CYC). A request that arrives early is held until the settling window ends. SETTLE_CYC defaults to 2.
- R7: Once `slave_rst_n` is high, the phase is 11 and both `bus_to_slave` and `slave_rst_n` stay high until system reset. Later writes and changes on `mst_rst_n` have no effect.
- R8: If `mst_rst_n` is sampled low in phase 01, the phase returns to 00 and a new rising edge restarts boot. In phases 10 and 11, `mst_rst_n` has no effect.
- R9: A single write with both bits set in phase 01 hands the bus to the slave and sets `release_err`. The release part of that write is not held for later, so `slave_rst_n` stays low until a new release request arrives.
- R10: `boot_phase` encodes 00 = waiting for master reset release, 01 = master booting, 10 = bus handed to slave and slave held in reset, 11 = slave running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, synchronous, active low |
| mst_rst_n | input | 1 | Master subsystem reset, active low, synchronous to clk |
| ctl_wr | input | 1 | Control write strobe from the master, one cycle per write |
| ctl_data | input | 2 | Control bits: bit 0 = give bus to slave, bit 1 = release slave |
| bus_to_slave | output | 1 | Bus select: 0 = master owns the external bus, 1 = slave owns it |
| slave_rst_n | output | 1 | Slave subsystem reset, active low |
| boot_phase | output | 2 | Current phase, encoded as in R10 |
| release_err | output | 1 | Sticky flag: a release was requested before the bus hand-over |

## Verification
The assertions assume that `mst_rst_n`, `ctl_wr` and `ctl_data` are already synchronous to `clk`. They also assume that a write strobe lasts exactly one cycle, so one write is one request. The stimulus changes every input only on the falling clock edge and drives each write for a single cycle. Boot is always started by holding `mst_rst_n` low for at least one sampled edge. Release requests are placed before, inside and after the settling window, so that the hold-and-apply path and the immediate path are both exercised.

// File: rtl/boot_seq_pkg.sv
// Shared types and constants for the boot bus sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package boot_seq_pkg;

    // Boot phase as reported on the status output.
    typedef enum logic [1:0] {
        PH_WAIT   = 2'b00,
        PH_BOOT   = 2'b01,
        PH_HANDED = 2'b10,
        PH_RUN    = 2'b11
    } boot_phase_e;

    // Control write layout: width and bit positions.
    localparam int unsigned CTL_BITS       = 2;
    localparam int unsigned BIT_GIVE_BUS   = 0;
    localparam int unsigned BIT_FREE_SLAVE = 1;

endpackage

// File: rtl/boot_mreset_edge.sv
// Detects a low-to-high transition of the master reset input.
// Assumes: mst_rst_n is synchronous to clk. During system reset the
// history register is preset high, so a level that is already high
// when reset ends does not count as a transition.
module boot_mreset_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_rst_n,
    output logic rise
);

    logic prev_q;

    // Keep the value of the master reset from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= mst_rst_n;
        end
    end

    // A rise is the current high level following a sampled low.
    assign rise = mst_rst_n & ~prev_q;

endmodule

// File: rtl/boot_settle_timer.sv
// Counts the cycles spent in the handed-over phase and flags when the
// bus-switch settling window has elapsed.
// Assumes: run stays high for the whole handed-over phase. The count
// saturates, so the window may last any number of cycles.
module boot_settle_timer #(
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Clear outside the window, count up inside it, and hold at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

    AST_SETTLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run) |=> (done || !run)); // R6

    AST_SETTLE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && (SETTLE_CYC > 1)) |-> !done); // R6

endmodule

// File: rtl/boot_seq_ctrl.sv
// Boot phase state machine. It owns the bus select, the slave reset
// and the early-release error flag.
// Assumes: a control write lasts one cycle. settle_done comes from the
// settle timer, which runs while settle_run is high.
module boot_seq_ctrl
    import boot_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mst_rst_n,
    input  logic                mst_rise,
    input  logic                wr_en,
    input  logic [CTL_BITS-1:0] wr_data,
    input  logic                settle_done,
    output boot_phase_e         phase,
    output logic                settle_run,
    output logic                bus_q,
    output logic                srst_n_q,
    output logic                err_q
);

    boot_phase_e state_q, state_d;
    logic        pend_q, pend_d;
    logic        give_req, free_req, err_d;

    assign give_req = wr_en & wr_data[BIT_GIVE_BUS];
    assign free_req = wr_en & wr_data[BIT_FREE_SLAVE];

    // Next phase, held release request and error flag.
    always_comb begin
        state_d = state_q;
        pend_d  = 1'b0;
        err_d   = err_q;
        unique case (state_q)
            PH_WAIT: begin
                if (free_req) err_d = 1'b1;
                if (mst_rise) state_d = PH_BOOT;
            end
            PH_BOOT: begin
                if (!mst_rst_n) begin
                    state_d = PH_WAIT;
                end else begin
                    if (free_req) err_d = 1'b1;
                    if (give_req) state_d = PH_HANDED;
                end
            end
            PH_HANDED: begin
                if (settle_done && (free_req || pend_q)) begin
                    state_d = PH_RUN;
                end else begin
                    pend_d = pend_q | free_req;
                end
            end
            PH_RUN: begin
                state_d = PH_RUN;
            end
            default: state_d = PH_WAIT;
        endcase
    end

    // Phase, held request and error flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_WAIT;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            err_q   <= err_d;
        end
    end

    // Registered pin drivers, decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q    <= 1'b0;
            srst_n_q <= 1'b0;
        end else begin
            bus_q    <= (state_d == PH_HANDED) || (state_d == PH_RUN);
            srst_n_q <= (state_d == PH_RUN);
        end
    end

    assign phase      = state_q;
    assign settle_run = (state_q == PH_HANDED);

    AST_SLAVE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_q |-> !srst_n_q); // R4

    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_q |=> bus_q); // R7

    AST_SLAVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        srst_n_q |=> srst_n_q); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R5

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !$past(bus_q)); // R5

    AST_RELEASE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_n_q) |-> $past(settle_done)); // R6

    AST_HANDOVER_FROM_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_q) |-> ($past(state_q) == PH_BOOT)); // R3

endmodule

// File: rtl/boot_bus_seq.sv
// Top level of the boot bus sequencer. It wires together the master
// reset edge detector, the phase controller and the settle timer.
// Assumes: all inputs are synchronous to clk. rst_n is the system reset.
module boot_bus_seq
    import boot_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mst_rst_n,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_data,
    output logic       bus_to_slave,
    output logic       slave_rst_n,
    output logic [1:0] boot_phase,
    output logic       release_err
);

    logic        mst_rise;
    logic        settle_run, settle_done;
    boot_phase_e phase;

    boot_mreset_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .mst_rst_n (mst_rst_n),
        .rise      (mst_rise)
    );

    boot_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .done  (settle_done)
    );

    boot_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mst_rst_n   (mst_rst_n),
        .mst_rise    (mst_rise),
        .wr_en       (ctl_wr),
        .wr_data     (ctl_data),
        .settle_done (settle_done),
        .phase       (phase),
        .settle_run  (settle_run),
        .bus_q       (bus_to_slave),
        .srst_n_q    (slave_rst_n),
        .err_q       (release_err)
    );

    assign boot_phase = phase;

    AST_RUN_MEANS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slave_rst_n) |-> (boot_phase == 2'b11)); // R10

endmodule

// File: tb/boot_bus_seq_test.sv
// Scoreboard bench: the driver pushes one expected item per cycle and
// the monitor pops and compares it just after the following edge.
module boot_bus_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mst_rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_data = 2'b00;
    logic       bus_to_slave, slave_rst_n, release_err;
    logic [1:0] boot_phase;

    typedef struct {
        logic       b;
        logic       s;
        logic [1:0] p;
        logic       e;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t it;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    boot_bus_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mst_rst_n    (mst_rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_data     (ctl_data),
        .bus_to_slave (bus_to_slave),
        .slave_rst_n  (slave_rst_n),
        .boot_phase   (boot_phase),
        .release_err  (release_err)
    );

    // Drive one cycle of inputs and queue the outputs expected after the next edge.
    task automatic step(input logic r, input logic m, input logic w, input logic [1:0] d,
                        input logic eb, input logic es, input logic [1:0] ep,
                        input logic ee, input string tag);
        @(negedge clk);
        rst_n = r; mst_rst_n = m; ctl_wr = w; ctl_data = d;
        q.push_back('{eb, es, ep, ee, tag});
    endtask

    // Monitor: compare the outputs against the scoreboard shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (bus_to_slave !== it.b || slave_rst_n !== it.s ||
                boot_phase !== it.p || release_err !== it.e) begin
                fails++;
                $display("FAIL %s: actual bus=%b srst=%b phase=%b err=%b expected bus=%b srst=%b phase=%b err=%b",
                         it.tag, bus_to_slave, slave_rst_n, boot_phase, release_err,
                         it.b, it.s, it.p, it.e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(0,0,0,2'b00, 0,0,2'b00,0, "R1 reset");
        step(0,0,0,2'b00, 0,0,2'b00,0, "R1 reset");
        // R2 level already high at reset exit: no boot; R2 hand-over ignored in wait
        step(1,1,0,2'b00, 0,0,2'b00,0, "R2 no edge");
        step(1,1,1,2'b01, 0,0,2'b00,0, "R2 write ignored");
        step(1,0,0,2'b00, 0,0,2'b00,0, "R2 low sampled");
        step(1,1,0,2'b00, 0,0,2'b01,0, "R2 rise starts boot R10");
        // R5 early release sets error, slave stays in reset
        step(1,1,1,2'b10, 0,0,2'b01,1, "R5 early release");
        step(1,1,0,2'b00, 0,0,2'b01,1, "R5 sticky");
        // R8 master reset during boot returns to wait, then reboots
        step(1,0,0,2'b00, 0,0,2'b00,1, "R8 back to wait");
        step(1,1,0,2'b00, 0,0,2'b01,1, "R8 reboot");
        // R3 hand-over, R6 early request held then applied at E0+2
        step(1,1,1,2'b01, 1,0,2'b10,1, "R3 hand-over");
        step(1,1,1,2'b10, 1,0,2'b10,1, "R6 early request held");
        step(1,1,0,2'b00, 1,1,2'b11,1, "R6 released at E0+2");
        // R7 nothing disturbs running
        step(1,0,1,2'b11, 1,1,2'b11,1, "R7 writes ignored");
        step(1,1,0,2'b00, 1,1,2'b11,1, "R7 still running");
        // R1 reset from running
        step(0,1,0,2'b00, 0,0,2'b00,0, "R1 reset from run");
        // R4 / R6 late request released at once
        step(1,0,0,2'b00, 0,0,2'b00,0, "R2 low sampled");
        step(1,1,0,2'b00, 0,0,2'b01,0, "R2 rise");
        step(1,1,1,2'b01, 1,0,2'b10,0, "R3 hand-over");
        step(1,1,0,2'b00, 1,0,2'b10,0, "R4 slave held");
        step(1,1,0,2'b00, 1,0,2'b10,0, "R4 slave held");
        step(1,1,0,2'b00, 1,0,2'b10,0, "R4 slave held");
        step(1,1,1,2'b10, 1,1,2'b11,0, "R6 late request immediate");
        step(0,0,0,2'b00, 0,0,2'b00,0, "R1 reset");
        // R9 both bits in one write; R8 master reset ignored after hand-over
        step(1,0,0,2'b00, 0,0,2'b00,0, "R2 low sampled");
        step(1,1,0,2'b00, 0,0,2'b01,0, "R2 rise");
        step(1,1,1,2'b11, 1,0,2'b10,1, "R9 combined write");
        step(1,0,0,2'b00, 1,0,2'b10,1, "R8 ignored in handed");
        step(1,1,0,2'b00, 1,0,2'b10,1, "R9 release not held");
        step(1,1,1,2'b10, 1,1,2'b11,1, "R9 new request releases");
        // R1 reset in the middle of the handed phase
        step(0,0,0,2'b00, 0,0,2'b00,0, "R1 reset");
        step(1,0,0,2'b00, 0,0,2'b00,0, "R2 low sampled");
        step(1,1,0,2'b00, 0,0,2'b01,0, "R2 rise");
        step(1,1,1,2'b01, 1,0,2'b10,0, "R3 hand-over");
        step(0,1,0,2'b00, 0,0,2'b00,0, "R1 reset from handed");
        step(1,1,0,2'b00, 0,0,2'b00,0, "R2 high at reset exit");
        step(1,1,1,2'b01, 0,0,2'b00,0, "R3 no hand-over from wait");
        @(negedge clk);
        ctl_wr = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule